// File: doc/BRIEF.md
# Parallel EEPROM Byte Controller

This block sits between a simple synchronous request port and an asynchronous byte-wide EEPROM with an 11-bit address and an 8-bit data bus. A host raises `req_valid` while `req_ready` is high to start either a byte read or a byte program. The controller generates the chip-enable, output-enable and write-enable strobes, drives the address, and drives the data bus through a split output/enable/input arrangement that maps onto a pad-level tri-state buffer.

Every strobe edge is placed by a down-counter. Its load values are derived at elaboration from nanosecond parameters and the clock period, always rounded up. After a program strobe the controller waits out the busy-assert delay. It then detects the end of the internal program cycle in one of two ways, chosen by a parameter. In the first, it re-reads the written address until bit 7 matches the written data. In the second, it waits for a synchronized open-drain ready line, which reads high through a pull-up once the device is ready. A cycle budget counted from the end of the strobe turns a program cycle that never finishes into an error pulse.

Top module: `eeprom_wctl`

## Requirements
- R1: During and just after reset, all three strobes are high, the data bus is not driven, `req_ready` is 1, and `rd_valid`, `wr_done` and `wr_err` are 0.
- R2: A read holds chip enable and output enable low, with write enable high, for ceil(max(address access, output-enable access) / clock period) cycles. With defaults at a 5 ns clock this is 30 cycles. The byte is then returned on `rd_data` with a one-cycle `rd_valid`, exactly that count plus 1 cycle after the request cycle.
- R3: The address is stable at least ceil(10 ns) cycles before write enable falls, and does not change for at least ceil(50 ns) cycles after it falls.
- R4: Write enable stays low for at least ceil(100 ns) cycles. The data bus is driven at least ceil(50 ns) cycles before write enable rises and is held for at least ceil(10 ns) cycles after.
- R5: Output enable is high at least ceil(10 ns) cycles before write enable falls and at least ceil(10 ns) cycles after it rises. Output enable and write enable are never low together, and the controller never drives the bus while both enables are low.
- R6: In polling mode (`USE_RDY`=0), the controller waits ceil(50 ns) cycles after the strobe and then repeatedly reads the written address. Between reads, both enables go high for one cycle. `wr_done` pulses once when data bit 7 reads equal to the written bit 7, and never while programming is still in progress.
- R7: In ready/busy mode (`USE_RDY`=1), `mem_rdy` (1 = ready, 0 = busy) passes through a two-stage synchronizer. `wr_done` pulses once after the busy-assert delay, when the synchronized line is seen high, and never while programming is still in progress.
- R8: If completion is not seen, `wr_err` pulses exactly `TIMEOUT_CYC` cycles after write enable rises. All strobes are then released and no `wr_done` is given.
- R9: `wr_done`, `wr_err` and `rd_valid` are single-cycle pulses, and `wr_done` and `wr_err` are never high together.
- R10: A request is taken only while `req_ready` is 1. While `req_ready` is 1 the strobes are inactive and the bus is released. A `req_valid` raised during an operation produces no read data and no access.
- R11: A programmed byte is returned unchanged by a later read of the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = program byte, 0 = read byte |
| req_addr | input | 11 | Byte address |
| req_wdata | input | 8 | Byte to program |
| req_ready | output | 1 | Controller idle, request accepted |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 8 | Read data |
| wr_done | output | 1 | Program cycle finished pulse |
| wr_err | output | 1 | Program completion timeout pulse |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | 11 | Memory address bus |
| mem_dq_out | output | 8 | Data toward memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 8 | Data from memory |
| mem_rdy | input | 1 | Open-drain ready/busy, high = ready |

## Verification
The bench models the memory as returning a garbage byte until enough access time has elapsed. A controller that samples one cycle early therefore returns the wrong data and misses the read latency check. The memory model also measures every setup, hold and pulse window around each write strobe, so a counter load that is short by one shows up as a timing violation. Writes with bit 7 set and clear exercise both polling polarities: a controller that compares against the wrong bit value either finishes while the model still reports busy or runs into the timeout. Stuck program cycles in both completion modes check that the error pulse arrives exactly on the budget cycle, and a stray request raised during each write checks that the controller does not start a second access.

// File: rtl/eeprom_wctl.sv
`timescale 1ns/1ps
module eeprom_wctl #(
  parameter int CLK_NS      = 5,
  parameter int ADDR_W      = 11,
  parameter int DATA_W      = 8,
  parameter int T_ACC_NS    = 150,
  parameter int T_OEA_NS    = 100,
  parameter int T_AS_NS     = 10,
  parameter int T_AH_NS     = 50,
  parameter int T_DS_NS     = 50,
  parameter int T_DH_NS     = 10,
  parameter int T_WP_NS     = 100,
  parameter int T_OES_NS    = 10,
  parameter int T_OEH_NS    = 10,
  parameter int T_BUSY_NS   = 50,
  parameter int USE_RDY     = 0,
  parameter int TIMEOUT_CYC = 220000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              wr_done,
  output logic              wr_err,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in,
  input  logic              mem_rdy
);

  function automatic int cyc(int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int SYNC_N = 2;
  localparam int ACC_C  = cyc(mx(T_ACC_NS, T_OEA_NS));
  localparam int SU_C   = cyc(mx(T_AS_NS, T_OES_NS));
  localparam int PL_C   = cyc(mx(T_WP_NS, T_DS_NS));
  localparam int HD_C   = mx(mx(cyc(T_DH_NS), cyc(T_OEH_NS)), cyc(T_AH_NS) - PL_C);
  localparam int BW_C   = cyc(T_BUSY_NS) + ((USE_RDY != 0) ? SYNC_N : 0);
  localparam int MAX_C  = mx(mx(ACC_C, SU_C), mx(mx(PL_C, HD_C), BW_C));
  localparam int CW     = $clog2(MAX_C + 1);
  localparam int TW     = $clog2(TIMEOUT_CYC + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_RD, S_WSU, S_WPL, S_WHD, S_WBW, S_PRD, S_PGAP, S_PRB
  } st_t;

  st_t               st;
  logic [CW-1:0]     cnt;
  logic [TW-1:0]     tmo;
  logic [ADDR_W-1:0] a_q;
  logic [DATA_W-1:0] d_q;
  logic              ce_q, oe_q, we_q, drv_q;
  logic [SYNC_N-1:0] rdy_sync;

  wire post    = (st == S_WHD) || (st == S_WBW) || (st == S_PRD) ||
                 (st == S_PGAP) || (st == S_PRB);
  wire cnt_z   = (cnt == '0);
  wire poll_ok = (mem_dq_in[DATA_W-1] == d_q[DATA_W-1]);
  wire fin     = (st == S_PRD && cnt_z && poll_ok) || (st == S_PRB && rdy_sync[SYNC_N-1]);
  wire tmo_hit = post && (tmo == TW'(TIMEOUT_CYC - 1));

  assign req_ready  = (st == S_IDLE);
  assign mem_ce_n   = ce_q;
  assign mem_oe_n   = oe_q;
  assign mem_we_n   = we_q;
  assign mem_addr   = a_q;
  assign mem_dq_out = d_q;
  assign mem_dq_oe  = drv_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rdy_sync <= '1;
    else        rdy_sync <= {rdy_sync[SYNC_N-2:0], mem_rdy};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; tmo <= '0;
      a_q <= '0; d_q <= '0; rd_data <= '0;
      ce_q <= 1'b1; oe_q <= 1'b1; we_q <= 1'b1; drv_q <= 1'b0;
      rd_valid <= 1'b0; wr_done <= 1'b0; wr_err <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      wr_done  <= 1'b0;
      wr_err   <= 1'b0;
      if (post) tmo <= tmo + 1'b1;
      if (!cnt_z) cnt <= cnt - 1'b1;
      case (st)
        S_IDLE:
          if (req_valid) begin
            a_q  <= req_addr;
            ce_q <= 1'b0;
            if (req_write) begin
              d_q <= req_wdata;
              cnt <= CW'(SU_C - 1);
              st  <= S_WSU;
            end else begin
              oe_q <= 1'b0;
              cnt  <= CW'(ACC_C - 1);
              st   <= S_RD;
            end
          end
        S_RD:
          if (cnt_z) begin
            rd_data  <= mem_dq_in;
            rd_valid <= 1'b1;
            ce_q     <= 1'b1;
            oe_q     <= 1'b1;
            st       <= S_IDLE;
          end
        S_WSU:
          if (cnt_z) begin
            we_q  <= 1'b0;
            drv_q <= 1'b1;
            cnt   <= CW'(PL_C - 1);
            st    <= S_WPL;
          end
        S_WPL:
          if (cnt_z) begin
            we_q <= 1'b1;
            tmo  <= '0;
            cnt  <= CW'(HD_C - 1);
            st   <= S_WHD;
          end
        S_WHD:
          if (cnt_z) begin
            drv_q <= 1'b0;
            ce_q  <= 1'b1;
            cnt   <= CW'(BW_C - 1);
            st    <= S_WBW;
          end
        S_WBW:
          if (cnt_z) begin
            if (USE_RDY != 0) st <= S_PRB;
            else begin
              ce_q <= 1'b0;
              oe_q <= 1'b0;
              cnt  <= CW'(ACC_C - 1);
              st   <= S_PRD;
            end
          end
        S_PRD:
          if (cnt_z) begin
            ce_q <= 1'b1;
            oe_q <= 1'b1;
            if (poll_ok) begin
              wr_done <= 1'b1;
              st      <= S_IDLE;
            end else st <= S_PGAP;
          end
        S_PGAP: begin
          ce_q <= 1'b0;
          oe_q <= 1'b0;
          cnt  <= CW'(ACC_C - 1);
          st   <= S_PRD;
        end
        S_PRB:
          if (rdy_sync[SYNC_N-1]) begin
            wr_done <= 1'b1;
            st      <= S_IDLE;
          end
        default: st <= S_IDLE;
      endcase
      if (tmo_hit && !fin) begin
        ce_q <= 1'b1; oe_q <= 1'b1; we_q <= 1'b1; drv_q <= 1'b0;
        wr_err <= 1'b1;
        st     <= S_IDLE;
      end
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe));
  p_rdv_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> $stable(mem_addr));
  p_data_at_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_dq_out)));
  p_we_ce_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_dq_oe));
  p_oe_we_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n));
  p_no_contention_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);
  p_done_err_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_done && wr_err));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> !wr_done);
  p_end_to_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_done || wr_err || rd_valid) |-> req_ready);

endmodule

// File: tb/eeprom_wctl_bench.sv
`timescale 1ns/1ps
module eeprom_mem_model #(
  parameter int AS_C = 2, AH_C = 10, DS_C = 10, DH_C = 2,
  parameter int WP_C = 20, OES_C = 2, OEH_C = 2, ACC_C = 30
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ce_n,
  input  logic        oe_n,
  input  logic        we_n,
  input  logic [10:0] addr,
  input  logic        dq_oe,
  input  logic [7:0]  dq,
  input  logic [15:0] prog_cyc,
  input  logic        stuck,
  output logic [7:0]  q,
  output logic        rdy,
  output logic [3:0]  viol
);
  logic [7:0]  mem [2048];
  logic        pwe, poe;
  logic [10:0] pa, wa, la;
  logic [8:0]  pd;
  int a_age, d_age, oe_age, fall_age, rise_age, low_w, acc, busy;
  logic fell, rose;

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = 8'hFF;
    viol = '0; busy = 0; acc = 0; low_w = 0;
    a_age = 1000; d_age = 1000; oe_age = 1000; fall_age = 1000; rise_age = 1000;
    pwe = 1'b1; poe = 1'b1; pa = '0; pd = '0; wa = '0; la = '0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      pwe = we_n; poe = oe_n; pa = addr; pd = {dq_oe, dq};
    end else begin
      fell = pwe && !we_n;
      rose = !pwe && we_n;
      a_age  = (addr != pa) ? 1 : a_age + 1;
      d_age  = ({dq_oe, dq} != pd) ? 1 : d_age + 1;
      oe_age = (oe_n != poe) ? 1 : oe_age + 1;
      if (fell) begin
        fall_age = 0; low_w = 0; wa = addr;
        if (a_age - 1 < AS_C) viol[0] = 1'b1;
        if (!oe_n || oe_age - 1 < OES_C) viol[2] = 1'b1;
      end else fall_age++;
      if (!we_n) low_w++;
      if (addr != pa && fall_age < AH_C) viol[0] = 1'b1;
      if (rose) begin
        rise_age = 0;
        if (!dq_oe || d_age - 1 < DS_C) viol[1] = 1'b1;
        if (low_w < WP_C) viol[1] = 1'b1;
        if (!ce_n) begin
          mem[wa] = dq; la = wa; busy = prog_cyc;
        end
      end else begin
        rise_age++;
        if (busy > 0 && !stuck) busy--;
      end
      if (({dq_oe, dq} != pd) && rise_age < DH_C) viol[1] = 1'b1;
      if ((oe_n != poe) && rise_age < OEH_C) viol[2] = 1'b1;
      if (!we_n && !oe_n) viol[2] = 1'b1;
      if (dq_oe && !ce_n && !oe_n) viol[3] = 1'b1;
      if (!ce_n && !oe_n) acc++; else acc = 0;
      pwe = we_n; poe = oe_n; pa = addr; pd = {dq_oe, dq};
    end
  end

  always_comb begin
    if (ce_n || oe_n)           q = 8'h00;
    else if (acc + 1 < ACC_C)   q = 8'hA5;
    else if (busy > 0 && addr == la) q = mem[addr] ^ 8'h80;
    else                        q = mem[addr];
  end
  assign rdy = (busy == 0);
endmodule

module eeprom_wctl_bench;
  localparam int CLK_NS = 5;
  localparam int TO = 300;

  function automatic int cyc(int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction
  localparam int ACC_C = cyc(150);

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0, stuck = 1'b0;
  logic [10:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic [15:0] pc = 16'd40;

  logic [1:0]  rdy_o, rdv, dn, er, cen, oen, wen, dqe, rb;
  logic [10:0] ma [2];
  logic [7:0]  rdd [2], dqo [2], q [2];
  logic [3:0]  viol [2];

  eeprom_wctl #(.CLK_NS(CLK_NS), .USE_RDY(0), .TIMEOUT_CYC(TO)) u_eeprom_wctl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(rdy_o[0]),
    .rd_valid(rdv[0]), .rd_data(rdd[0]), .wr_done(dn[0]), .wr_err(er[0]),
    .mem_ce_n(cen[0]), .mem_oe_n(oen[0]), .mem_we_n(wen[0]), .mem_addr(ma[0]),
    .mem_dq_out(dqo[0]), .mem_dq_oe(dqe[0]), .mem_dq_in(q[0]), .mem_rdy(rb[0]));

  eeprom_wctl #(.CLK_NS(CLK_NS), .USE_RDY(1), .TIMEOUT_CYC(TO)) u_eeprom_wctl_rb (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(rdy_o[1]),
    .rd_valid(rdv[1]), .rd_data(rdd[1]), .wr_done(dn[1]), .wr_err(er[1]),
    .mem_ce_n(cen[1]), .mem_oe_n(oen[1]), .mem_we_n(wen[1]), .mem_addr(ma[1]),
    .mem_dq_out(dqo[1]), .mem_dq_oe(dqe[1]), .mem_dq_in(q[1]), .mem_rdy(rb[1]));

  eeprom_mem_model #(.AS_C(cyc(10)), .AH_C(cyc(50)), .DS_C(cyc(50)), .DH_C(cyc(10)),
    .WP_C(cyc(100)), .OES_C(cyc(10)), .OEH_C(cyc(10)), .ACC_C(ACC_C)) m_poll (
    .clk(clk), .rst_n(rst_n), .ce_n(cen[0]), .oe_n(oen[0]), .we_n(wen[0]),
    .addr(ma[0]), .dq_oe(dqe[0]), .dq(dqo[0]), .prog_cyc(pc), .stuck(stuck),
    .q(q[0]), .rdy(rb[0]), .viol(viol[0]));

  eeprom_mem_model #(.AS_C(cyc(10)), .AH_C(cyc(50)), .DS_C(cyc(50)), .DH_C(cyc(10)),
    .WP_C(cyc(100)), .OES_C(cyc(10)), .OEH_C(cyc(10)), .ACC_C(ACC_C)) m_rb (
    .clk(clk), .rst_n(rst_n), .ce_n(cen[1]), .oe_n(oen[1]), .we_n(wen[1]),
    .addr(ma[1]), .dq_oe(dqe[1]), .dq(dqo[1]), .prog_cyc(pc), .stuck(stuck),
    .q(q[1]), .rdy(rb[1]), .viol(viol[1]));

  int checks = 0, errors = 0, ncyc = 0, req_c = 0;
  int n_done [2], n_err [2], n_rdv [2], n_bad [2], rise_c [2], err_lat [2], rlat [2];
  logic [7:0] rdat [2];
  logic [1:0] pwe = 2'b11;
  logic [7:0] exp_mem [2048];
  logic [10:0] hist [8];

  always @(posedge clk) ncyc++;

  always @(negedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (!pwe[i] && wen[i]) rise_c[i] = ncyc;
      if (dn[i]) begin n_done[i]++; if (!rb[i]) n_bad[i]++; end
      if (er[i]) begin n_err[i]++; err_lat[i] = ncyc - rise_c[i]; end
      if (rdv[i]) begin n_rdv[i]++; rdat[i] = rdd[i]; rlat[i] = ncyc - req_c; end
      pwe[i] = wen[i];
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic string mode(int i);
    return (i == 0) ? "poll" : "rdybusy";
  endfunction

  task automatic do_write(input logic [10:0] a, input logic [7:0] d, input int p, input bit stk);
    @(negedge clk); #1;
    for (int i = 0; i < 2; i++) begin n_done[i] = 0; n_err[i] = 0; n_rdv[i] = 0; n_bad[i] = 0; end
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    pc = p[15:0]; stuck = stk;
    @(negedge clk); #1; req_valid = 1'b0;
    repeat (4) @(negedge clk);
    #1; req_valid = 1'b1; req_write = 1'b0; req_addr = ~a;
    @(negedge clk); #1; req_valid = 1'b0;
    for (int k = 0; k < 2000 && !((n_done[0] + n_err[0]) > 0 && (n_done[1] + n_err[1]) > 0); k++)
      @(negedge clk);
    repeat (2) @(negedge clk);
    #1;
    exp_mem[a] = d;
    for (int i = 0; i < 2; i++) begin
      if (stk) begin
        chk(n_err[i] == 1 && n_done[i] == 0, {"R8 timeout error pulse ", mode(i)}, n_err[i], 1);
        chk(err_lat[i] == TO, {"R8 timeout latency ", mode(i)}, err_lat[i], TO);
      end else if (i == 0) begin
        chk(n_done[i] == 1 && n_err[i] == 0, "R6 poll done pulse", n_done[i], 1);
        chk(n_bad[i] == 0, "R6 poll done while busy", n_bad[i], 0);
      end else begin
        chk(n_done[i] == 1 && n_err[i] == 0, "R7 ready/busy done pulse", n_done[i], 1);
        chk(n_bad[i] == 0, "R7 ready/busy done while busy", n_bad[i], 0);
      end
      chk(n_rdv[i] == 0, {"R10 stray request ignored ", mode(i)}, n_rdv[i], 0);
      chk(rdy_o[i] == 1'b1, {"R9 idle after completion ", mode(i)}, rdy_o[i], 1);
      chk(viol[i][0] == 1'b0, {"R3 address window ", mode(i)}, viol[i][0], 0);
      chk(viol[i][1] == 1'b0, {"R4 data window and pulse ", mode(i)}, viol[i][1], 0);
      chk(viol[i][3:2] == 2'b00, {"R5 output enable guard ", mode(i)}, viol[i][3:2], 0);
    end
    stuck = 1'b0;
    for (int k = 0; k < 1000 && !(rb[0] && rb[1]); k++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic do_read(input logic [10:0] a);
    @(negedge clk); #1;
    for (int i = 0; i < 2; i++) n_rdv[i] = 0;
    req_c = ncyc;
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk); #1; req_valid = 1'b0;
    for (int k = 0; k < 200 && !(n_rdv[0] > 0 && n_rdv[1] > 0); k++) @(negedge clk);
    @(negedge clk); #1;
    for (int i = 0; i < 2; i++) begin
      chk(n_rdv[i] == 1, {"R9 one read valid pulse ", mode(i)}, n_rdv[i], 1);
      chk(rdat[i] == exp_mem[a], {"R11 read back data ", mode(i)}, rdat[i], exp_mem[a]);
      chk(rlat[i] == ACC_C + 1, {"R2 read latency ", mode(i)}, rlat[i], ACC_C + 1);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL all: watchdog expired act=%0d exp=%0d", ncyc, 0);
    summary();
    $finish;
  end

  initial begin
    int op, sel;
    logic [10:0] ra;
    logic [7:0]  rd;
    void'($urandom(32'd4711));
    for (int i = 0; i < 2048; i++) exp_mem[i] = 8'hFF;
    for (int i = 0; i < 8; i++) hist[i] = 11'(i);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      chk(cen[i] && oen[i] && wen[i] && !dqe[i], {"R1 strobes idle in reset ", mode(i)},
          {cen[i], oen[i], wen[i], dqe[i]}, 4'b1110);
      chk(rdy_o[i] && !rdv[i] && !dn[i] && !er[i], {"R1 status in reset ", mode(i)},
          {rdy_o[i], rdv[i], dn[i], er[i]}, 4'b1000);
    end
    #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 2; i++)
      chk(rdy_o[i] && cen[i] && wen[i], {"R1 idle after reset ", mode(i)}, rdy_o[i], 1);

    do_write(11'd0, 8'h3C, 40, 1'b0);
    do_write(11'd2047, 8'hC5, 90, 1'b0);
    do_read(11'd0);
    do_read(11'd2047);
    do_read(11'd5);
    do_write(11'd100, 8'h81, 60, 1'b1);
    do_read(11'd100);
    do_write(11'd100, 8'h02, 20, 1'b0);
    do_write(11'd101, 8'h7F, 150, 1'b1);
    do_read(11'd100);

    for (int n = 0; n < 24; n++) begin
      op = $urandom % 3;
      if (op != 0) begin
        ra = 11'($urandom);
        rd = 8'($urandom);
        hist[n % 8] = ra;
        do_write(ra, rd, 20 + ($urandom % 130), 1'b0);
      end else begin
        sel = $urandom % 8;
        do_read(hist[sel]);
      end
    end

    summary();
    $finish;
  end
endmodule